// File: doc/BRIEF.md
# Smart Card Frame Transmitter with Error-Signal Retry

This block sends bytes over a single half-duplex data line shared with a receiver. The line is open-drain: a pull-up holds it high, and the block can only pull it low or release it.

Each byte goes out as an asynchronous frame of twelve bit times:

- bit 0: a low start bit;
- bits 1 to 8: eight data bits;
- bit 9: one parity bit;
- bits 10 and 11: a guard time of two released bit times.

During the guard time the block listens for a low pulse from the receiver, which reports a parity error. If it sees one, it sends the same byte again from the start bit, up to a configurable number of resends. If that number runs out, it drops the byte and raises a hard-error flag.

Bit timing comes from an external sub-tick strobe. One bit time is `SUB_PER_BIT` sub-ticks. Configuration inputs choose:

- even or odd parity;
- LSB-first or MSB-first data order;
- inverted data and parity levels.

These inputs are captured together with the byte when it is accepted. The status flags report that a frame completed, that an error signal was seen, or that the byte was dropped. All three flags stay set until the next byte is accepted.

Top module: `sc_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_ready` is 1 and `line_pull` is 0, and after reset `tx_end`, `err_seen` and `hard_err` are 0.
- R2: An accepted byte (`tx_valid` and `tx_ready` at a clock edge) starts a frame on the next cycle. The frame is a start bit with the line pulled low, then eight data bits, then one parity bit. Each bit lasts `SUB_PER_BIT` sub-ticks. A logic level of 0 means `line_pull`=1 and a level of 1 means `line_pull`=0.
- R3: With `cfg_odd`=0 the number of ones among the eight data bits and the parity bit is even. With `cfg_odd`=1 that number is odd.
- R4: With `cfg_msb_first`=0 data bit 0 is sent first. With `cfg_msb_first`=1 data bit 7 is sent first.
- R5: With `cfg_invert`=1 the line level of every data bit and of the parity bit is the complement of its value. The start bit stays low.
- R6: For the two bit times after the parity bit the line is released. `line_in` is sampled on sub-tick `SUB_PER_BIT/2` of the first of these two bits. A low sample is an error signal and sets `err_seen`.
- R7: After an error signal, once the two released bit times end, the same byte is sent again from the start bit, as long as resends remain.
- R8: A frame with no error signal sets `tx_end` and returns to ready only after the two released bit times end. Accepting a new byte clears `tx_end`, `err_seen` and `hard_err`.
- R9: A byte is resent at most `cfg_max_retry` times. An error signal on the last allowed attempt sets `hard_err`, leaves `tx_end` at 0, drops the byte and returns to ready.
- R10: The byte and the configuration are captured on acceptance. Changes to `tx_data`, to the configuration inputs and to `tx_valid` while a frame is in progress have no effect on that frame. A `tx_valid` held high at completion is accepted on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sub-tick strobe; `SUB_PER_BIT` strobes make one bit time |
| tx_valid | input | 1 | Byte offered |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block idle and able to accept a byte |
| cfg_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_msb_first | input | 1 | 1 sends bit 7 first, 0 sends bit 0 first |
| cfg_invert | input | 1 | 1 inverts data and parity levels on the line |
| cfg_max_retry | input | RETRY_W | Maximum number of resends per byte |
| line_in | input | 1 | Sampled level of the shared line |
| line_pull | output | 1 | 1 pulls the line low, 0 releases it |
| tx_end | output | 1 | Last byte completed without an error signal |
| err_seen | output | 1 | An error signal was seen for the current byte |
| hard_err | output | 1 | Resends ran out and the byte was dropped |

## Verification
Two events can fall in the same cycle: the sub-tick that closes the guard time, which ends a frame, and a byte already waiting on `tx_valid`. The bench holds `tx_valid` high across a whole frame and scrambles `tx_data` and `cfg_odd` while that frame is in progress. It then judges three things:

- the frame still carries the captured byte and parity;
- `tx_end` is seen high for the one cycle before the next acceptance;
- the waiting byte is taken exactly one cycle later with the flags cleared.

A second overlap is an error pulse that arrives on the last allowed attempt. It must raise `hard_err` instead of starting another frame.

// File: rtl/sc_frame_tx.sv
module sc_frame_tx #(
  parameter int SUB_PER_BIT = 16,
  parameter int RETRY_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               tx_valid,
  input  logic [7:0]         tx_data,
  output logic               tx_ready,
  input  logic               cfg_odd,
  input  logic               cfg_msb_first,
  input  logic               cfg_invert,
  input  logic [RETRY_W-1:0] cfg_max_retry,
  input  logic               line_in,
  output logic               line_pull,
  output logic               tx_end,
  output logic               err_seen,
  output logic               hard_err
);
  localparam int SUB_W    = (SUB_PER_BIT > 2) ? $clog2(SUB_PER_BIT) : 1;
  localparam int MID      = SUB_PER_BIT / 2;
  localparam int PAR_BIT  = 9;
  localparam int WIN_BIT  = 10;
  localparam int LAST_BIT = 11;

  logic               busy;
  logic [3:0]         bit_idx;
  logic [SUB_W-1:0]   sub;
  logic [7:0]         byte_q;
  logic               odd_q, msb_q, inv_q;
  logic [RETRY_W-1:0] max_q, retry_q;
  logic               err_frame;
  logic               level;
  logic               drive;

  wire       accept   = tx_valid && !busy;
  wire       sub_last = (sub == SUB_W'(SUB_PER_BIT - 1));
  wire       win_smp  = busy && tick && (bit_idx == 4'(WIN_BIT)) && (sub == SUB_W'(MID));
  wire [2:0] k        = 3'(bit_idx - 4'd1);
  wire       data_bit = msb_q ? byte_q[3'd7 - k] : byte_q[k];
  wire       par_bit  = (^byte_q) ^ odd_q;

  always_comb begin
    drive = 1'b1;
    level = 1'b1;
    if (bit_idx == 4'd0)                  level = 1'b0;
    else if (bit_idx < 4'(PAR_BIT))       level = data_bit ^ inv_q;
    else if (bit_idx == 4'(PAR_BIT))      level = par_bit ^ inv_q;
    else                                  drive = 1'b0;
  end

  assign tx_ready  = !busy;
  assign line_pull = busy && drive && !level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bit_idx   <= '0;
      sub       <= '0;
      byte_q    <= '0;
      odd_q     <= 1'b0;
      msb_q     <= 1'b0;
      inv_q     <= 1'b0;
      max_q     <= '0;
      retry_q   <= '0;
      err_frame <= 1'b0;
      tx_end    <= 1'b0;
      err_seen  <= 1'b0;
      hard_err  <= 1'b0;
    end else if (accept) begin
      busy      <= 1'b1;
      bit_idx   <= '0;
      sub       <= '0;
      byte_q    <= tx_data;
      odd_q     <= cfg_odd;
      msb_q     <= cfg_msb_first;
      inv_q     <= cfg_invert;
      max_q     <= cfg_max_retry;
      retry_q   <= '0;
      err_frame <= 1'b0;
      tx_end    <= 1'b0;
      err_seen  <= 1'b0;
      hard_err  <= 1'b0;
    end else if (busy && tick) begin
      if (win_smp && !line_in) begin
        err_frame <= 1'b1;
        err_seen  <= 1'b1;
      end
      if (!sub_last) begin
        sub <= sub + 1'b1;
      end else begin
        sub <= '0;
        if (bit_idx != 4'(LAST_BIT)) begin
          bit_idx <= bit_idx + 4'd1;
        end else if (!err_frame) begin
          tx_end <= 1'b1;
          busy   <= 1'b0;
        end else if (retry_q == max_q) begin
          hard_err <= 1'b1;
          busy     <= 1'b0;
        end else begin
          retry_q   <= retry_q + 1'b1;
          bit_idx   <= '0;
          err_frame <= 1'b0;
        end
      end
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !line_pull);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx == 4'd0) |-> line_pull);
  assert_guard_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx >= 4'(WIN_BIT)) |-> !line_pull);
  assert_end_after_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> ($past(bit_idx) == 4'(LAST_BIT)));
  assert_retry_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= max_q);
  assert_end_hard_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_end && hard_err));
  assert_byte_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(byte_q));
endmodule

// File: tb/tb_sc_frame_tx.sv
module tb_sc_frame_tx;
  localparam int SUB = 4;
  localparam int RW  = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, tick, tx_valid, tx_ready;
  logic [7:0]    tx_data;
  logic          cfg_odd, cfg_msb, cfg_inv;
  logic [RW-1:0] cfg_max;
  logic          rx_pull, line_pull, tx_end, err_seen, hard_err;
  wire           line_in = !(line_pull || rx_pull);

  sc_frame_tx #(.SUB_PER_BIT(SUB), .RETRY_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .cfg_odd(cfg_odd), .cfg_msb_first(cfg_msb), .cfg_invert(cfg_inv),
    .cfg_max_retry(cfg_max), .line_in(line_in), .line_pull(line_pull),
    .tx_end(tx_end), .err_seen(err_seen), .hard_err(hard_err));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_frame(input logic [7:0] d, input logic odd,
                                           input logic msb, input logic inv);
    logic [9:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = (msb ? d[7-i] : d[i]) ^ inv;
    f[9] = (^d) ^ odd ^ inv;
    return f;
  endfunction

  task automatic do_frame(input logic [7:0] d, input logic odd, input logic msb,
                          input logic inv, input logic [RW-1:0] maxr, input int nerr,
                          input bit keep, input bit chained);
    int n;
    int attempts;
    logic [9:0] got;
    tx_data = d; cfg_odd = odd; cfg_msb = msb; cfg_inv = inv; cfg_max = maxr;
    tx_valid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (tx_ready && n < 50);
    if (chained) begin
      check("R10 pending byte accepted next cycle", n, 1);
      check("R8 tx_end cleared on accept", int'(tx_end), 0);
    end
    if (keep) begin
      tx_data = ~d;
      cfg_odd = ~odd;
    end else begin
      tx_valid = 1'b0;
    end
    attempts = (nerr > int'(maxr)) ? int'(maxr) + 1 : nerr + 1;
    for (int a = 0; a < attempts; a++) begin
      n = 0;
      while (!line_pull && n < 300) begin
        @(negedge clk);
        n++;
      end
      check("R7 frame start seen", int'(line_pull), 1);
      for (int i = 0; i < 10; i++) begin
        repeat ((i == 0) ? 4 : 8) @(negedge clk);
        got[i] = !line_pull;
      end
      check(a == 0 ? "R2/R3/R4/R5/R10 frame levels" : "R7 resent frame levels",
            int'(got), int'(exp_frame(d, odd, msb, inv)));
      if (a < nerr) begin
        repeat (4) @(negedge clk);
        rx_pull = 1'b1;
        repeat (12) @(negedge clk);
        rx_pull = 1'b0;
        check("R6 err_seen after error pulse", int'(err_seen), 1);
      end else begin
        repeat (12) @(negedge clk);
        check("R8 still busy inside guard time", int'(tx_ready), 0);
        check("R6 line released in guard time", int'(line_pull), 0);
      end
    end
    n = 0;
    while (!tx_ready && n < 300) begin
      @(negedge clk);
      n++;
    end
    check("R1 ready after frame", int'(tx_ready), 1);
    check("R1 line released when idle", int'(line_pull), 0);
    check("R8 tx_end", int'(tx_end), int'(nerr <= int'(maxr)));
    check("R9 hard_err", int'(hard_err), int'(nerr > int'(maxr)));
    check("R6 err_seen", int'(err_seen), int'(nerr > 0));
  endtask

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0; rx_pull = 1'b0;
    cfg_odd = 1'b0; cfg_msb = 1'b0; cfg_inv = 1'b0; cfg_max = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", int'(tx_ready), 1);
    check("R1 reset line", int'(line_pull), 0);
    check("R1 reset flags", int'({tx_end, err_seen, hard_err}), 0);

    do_frame(8'hA5, 1'b0, 1'b0, 1'b0, 2'd2, 0, 1'b0, 1'b0);
    do_frame(8'h3C, 1'b1, 1'b0, 1'b0, 2'd2, 0, 1'b0, 1'b0);
    do_frame(8'h1E, 1'b0, 1'b1, 1'b0, 2'd2, 0, 1'b0, 1'b0);
    do_frame(8'h6B, 1'b1, 1'b1, 1'b1, 2'd2, 0, 1'b0, 1'b0);
    do_frame(8'hC3, 1'b0, 1'b0, 1'b0, 2'd2, 1, 1'b0, 1'b0);
    do_frame(8'h5A, 1'b1, 1'b0, 1'b1, 2'd2, 2, 1'b0, 1'b0);
    do_frame(8'h77, 1'b0, 1'b0, 1'b0, 2'd1, 2, 1'b0, 1'b0);
    do_frame(8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 1, 1'b0, 1'b0);
    do_frame(8'h96, 1'b0, 1'b0, 1'b0, 2'd1, 0, 1'b1, 1'b0);
    do_frame(8'h2D, 1'b1, 1'b1, 1'b0, 2'd1, 0, 1'b0, 1'b1);

    for (int r = 0; r < 12; r++) begin
      logic [7:0] d;
      logic [3:0] c;
      int ne;
      d  = 8'($urandom);
      c  = 4'($urandom);
      ne = int'($urandom % 3);
      do_frame(d, c[0], c[1], c[2], RW'($urandom), ne, 1'b0, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule